// File: doc/BRIEF.md
# Inter-Processor Mailbox

This block lets up to four processors on one chip hand each other short messages. There are eight channels, and each channel holds a single 64-bit message in eight byte-wide slot registers. Any processor may post on any channel to any processor, including itself. Each processor has three things of its own: an enable mask, which says which channels may raise its pending state; a write-one-to-clear register; and a pending-status byte. A shared trigger register turns a channel bitmask into pending bits, but only for the targets whose mask has that channel enabled. Each processor has a level-high interrupt line that stays asserted while any of its pending bits is set.

A sender first writes the eight message bytes. It then clears the channel's bit at the target, sets the bit in the target's enable mask with a read-modify-write, and writes the bit to the trigger. The receiver reads its status, clears the bits it handled, and removes those bits from its own enable mask. A sender can then read that mask back: a 0 in the channel's bit means the last message was taken.

The register bus is byte-wide and byte-addressed. Writes take effect at the clock edge where the write strobe is high. Read data appears on the cycle after the read strobe.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all 64 message bytes, all four enable masks and all pending bits are 0. Every interrupt is low and the read data is 0.
- R2: Offset 0x400 + 8*n + k holds byte k of channel n's message, for n in 0..7 and k in 0..7. Byte k carries message bits 8k+7 down to 8k. The byte reads back what was last written to it.
- R3: Offset 4*c (c in 0..3) is processor c's enable mask, which can be read and written. Bit n stands for channel n. A receiver clearing its bit reads back as 0 to the sender.
- R4: Writing value t to the trigger at offset 0x60 sets pending bit n of processor c for every c whose enable mask has bit n set and t has bit n set. Other pending bits are unchanged. This includes a sender targeting itself.
- R5: Offset 0x18 + 16*c reads processor c's pending byte, with bit n for channel n.
- R6: Writing value x to offset 0x10 + 16*c clears each pending bit of processor c where x has a 1. Bits where x has a 0 are unchanged, so writing 0 changes nothing.
- R7: Interrupt line c is high exactly while processor c has any pending bit set. It rises on the cycle after the trigger write and falls on the cycle after the clear that removes the last pending bit.
- R8: Reads of unmapped offsets return 0, and so do reads of the clear and trigger registers. Writes to unmapped offsets or to the status registers change no state.
- R9: Read data is the addressed value on the cycle after the read strobe is sampled high. It is 0 on any cycle after the strobe was sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe for the byte at busAddr |
| busRe | input | 1 | Read strobe; data is returned on the next cycle |
| busAddr | input | 12 | Byte offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| irq | output | 4 | Level-high interrupt, one bit per processor |

## Verification
A wrong enable mask or pending bit shows up on the interrupt line by the next cycle after the trigger or clear write that touches it. It also shows in the status byte read back one cycle after the read strobe. For that reason, the bench sweeps every trigger value against four distinct masks and compares every status byte and the interrupt vector after each write. A decode error that hits the wrong register is exposed by reading back all mapped state after the unmapped writes. Slot corruption only becomes visible when the affected byte is read, so every byte is read back after each phase.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_CPUS       = 4;
  localparam int MB_CHANS      = 8;
  localparam int MB_DATA_W     = 8;
  localparam int MB_ADDR_W     = 12;
  localparam int MB_MSG_BYTES  = 8;
  localparam int MB_SLOT_BYTES = MB_CHANS * MB_MSG_BYTES;
  localparam int MB_SLOT_AW    = $clog2(MB_SLOT_BYTES);
  localparam int MB_CPU_W      = $clog2(MB_CPUS);

  // register placement (software decodes these offsets)
  localparam int MB_EN_BASE    = 'h000;
  localparam int MB_EN_STRIDE  = 4;
  localparam int MB_CLR_BASE   = 'h010;
  localparam int MB_STAT_BASE  = 'h018;
  localparam int MB_CPU_STRIDE = 'h010;
  localparam int MB_TRIG_ADDR  = 'h060;
  localparam int MB_SLOT_BASE  = 'h400;

  typedef enum logic [1:0] {RD_NONE, RD_MASK, RD_STAT, RD_SLOT} rdSel_e;

  typedef struct packed {
    logic [MB_CPUS-1:0]    enWr;
    logic [MB_CPUS-1:0]    clrWr;
    logic                  trigWr;
    logic                  slotWr;
    logic [MB_SLOT_AW-1:0] slotIdx;
    rdSel_e                rdSel;
    logic [MB_CPU_W-1:0]   rdCpu;
  } mbStrobe_t;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W = MB_ADDR_W
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output mbStrobe_t         stb
);
  logic [MB_CPUS-1:0]  hitEn;
  logic [MB_CPUS-1:0]  hitClr;
  logic [MB_CPUS-1:0]  hitStat;
  logic                hitTrig;
  logic                hitSlot;
  logic [MB_CPU_W-1:0] cpuSel;

  always_comb begin
    hitEn   = '0;
    hitClr  = '0;
    hitStat = '0;
    cpuSel  = '0;
    for (int c = 0; c < MB_CPUS; c++) begin
      if (busAddr == ADDR_W'(MB_EN_BASE + c * MB_EN_STRIDE)) begin
        hitEn[c] = 1'b1;
        cpuSel   = MB_CPU_W'(c);
      end
      if (busAddr == ADDR_W'(MB_CLR_BASE + c * MB_CPU_STRIDE)) begin
        hitClr[c] = 1'b1;
        cpuSel    = MB_CPU_W'(c);
      end
      if (busAddr == ADDR_W'(MB_STAT_BASE + c * MB_CPU_STRIDE)) begin
        hitStat[c] = 1'b1;
        cpuSel     = MB_CPU_W'(c);
      end
    end
    hitTrig = (busAddr == ADDR_W'(MB_TRIG_ADDR));
    hitSlot = (int'(busAddr) >= MB_SLOT_BASE) &&
              (int'(busAddr) < MB_SLOT_BASE + MB_SLOT_BYTES);
  end

  always_comb begin
    stb.enWr    = hitEn  & {MB_CPUS{busWe}};
    stb.clrWr   = hitClr & {MB_CPUS{busWe}};
    stb.trigWr  = hitTrig & busWe;
    stb.slotWr  = hitSlot & busWe;
    stb.slotIdx = MB_SLOT_AW'(busAddr);
    stb.rdCpu   = cpuSel;
    if (!busRe)          stb.rdSel = RD_NONE;
    else if (|hitEn)     stb.rdSel = RD_MASK;
    else if (|hitStat)   stb.rdSel = RD_STAT;
    else if (hitSlot)    stb.rdSel = RD_SLOT;
    else                 stb.rdSel = RD_NONE;
  end

  // R8: a write never lands in two register kinds at once
  always_comb begin
    p_single_target_r8: assert ($onehot0({|stb.enWr, |stb.clrWr, stb.trigWr, stb.slotWr}));
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int NUM_CPU  = MB_CPUS,
  parameter int NUM_CHAN = MB_CHANS,
  parameter int DATA_W   = MB_DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mbStrobe_t          stb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_CPU-1:0] irq
);
  localparam int SLOT_BYTES = NUM_CHAN * MB_MSG_BYTES;

  logic [NUM_CHAN-1:0] enMask  [NUM_CPU];
  logic [NUM_CHAN-1:0] pend    [NUM_CPU];
  logic [DATA_W-1:0]   slotMem [SLOT_BYTES];
  logic [NUM_CHAN-1:0] chanBits;
  logic [DATA_W-1:0]   rdVal;

  assign chanBits = wrData[NUM_CHAN-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        enMask[c] <= '0;
        pend[c]   <= '0;
      end
      for (int b = 0; b < SLOT_BYTES; b++) slotMem[b] <= '0;
      rdData <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (stb.enWr[c]) enMask[c] <= chanBits;
        // trigger is OR-ed after the clear, so it wins on a collision
        pend[c] <= (pend[c] & ~(stb.clrWr[c] ? chanBits : '0))
                 | (stb.trigWr ? (chanBits & enMask[c]) : '0);
      end
      if (stb.slotWr) slotMem[stb.slotIdx] <= wrData;
      rdData <= rdVal;
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_MASK: rdVal = DATA_W'(enMask[stb.rdCpu]);
      RD_STAT: rdVal = DATA_W'(pend[stb.rdCpu]);
      RD_SLOT: rdVal = slotMem[stb.slotIdx];
      default: rdVal = '0;
    endcase
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign irq[c] = |pend[c];

    // R4: an enabled trigger raises the line on the next cycle
    p_trig_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.trigWr && ((chanBits & enMask[c]) != '0)) |=> irq[c]);

    // R4: pending bits only appear through the trigger
    p_no_spurious_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !stb.trigWr |=> ((pend[c] & ~$past(pend[c])) == '0));

    // R6: cleared bits are gone unless a trigger collides
    p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.clrWr[c] && !stb.trigWr) |=> ((pend[c] & $past(chanBits)) == '0));

    // R3: masks change only through their own write
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !stb.enWr[c] |=> $stable(enMask[c]));
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int ADDR_W  = MB_ADDR_W,
  parameter int DATA_W  = MB_DATA_W,
  parameter int NUM_CPU = MB_CPUS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_CPU-1:0] irq
);
  mbStrobe_t stb;

  mbox_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .stb     (stb)
  );

  mbox_datapath #(
    .NUM_CPU  (NUM_CPU),
    .NUM_CHAN (MB_CHANS),
    .DATA_W   (DATA_W)
  ) u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wrData (busWdata),
    .rdData (busRdata),
    .irq    (irq)
  );

  // R9: no read strobe, no data next cycle
  p_idle_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busRe |=> (busRdata == '0));
endmodule

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [3:0]  irq;

  ipc_mailbox u_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] expEn   [4];
  logic [7:0] expPend [4];
  logic [7:0] expSlot [64];
  int tests = 0;
  int fails = 0;

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  // bus write plus the effect the requirements give it
  task automatic modelWrite(input logic [11:0] a, input logic [7:0] d);
    busWrite(a, d);
    if (a < 12'h010 && a[1:0] == 2'b00) expEn[a[3:2]] = d;
    else if (a >= 12'h010 && a < 12'h050 && a[3:0] == 4'h0) expPend[(a - 12'h010) >> 4] &= ~d;
    else if (a == 12'h060) begin
      for (int c = 0; c < 4; c++) expPend[c] |= d & expEn[c];
    end
    else if (a >= 12'h400 && a < 12'h440) expSlot[a - 12'h400] = d;
  endtask

  function automatic logic [3:0] expIrq();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) v[c] = |expPend[c];
    return v;
  endfunction

  task automatic checkIrq(input string req);
    check(req, "irq", {4'b0, irq}, {4'b0, expIrq()});
  endtask

  task automatic verifyAll(input string req);
    logic [7:0] v;
    for (int c = 0; c < 4; c++) begin
      busRead(12'(c * 4), v);           check(req, $sformatf("mask%0d", c), v, expEn[c]);
      busRead(12'(12'h018 + c * 16), v); check(req, $sformatf("stat%0d", c), v, expPend[c]);
    end
    for (int i = 0; i < 64; i++) begin
      busRead(12'(12'h400 + i), v);
      check(req, $sformatf("slot byte %0d", i), v, expSlot[i]);
    end
    checkIrq(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int c = 0; c < 4; c++) begin expEn[c] = '0; expPend[c] = '0; end
    for (int i = 0; i < 64; i++) expSlot[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1", "rdata", busRdata, 8'h00);
    checkIrq("R1");
    verifyAll("R1");

    // R2: every message byte
    for (int i = 0; i < 64; i++) modelWrite(12'(12'h400 + i), 8'((i * 37 + 5) & 8'hFF));
    verifyAll("R2");
    busRead(12'h42B, v);
    check("R2", "chan5 byte3", v, 8'((43 * 37 + 5) & 8'hFF));

    // R3: enable masks
    modelWrite(12'h000, 8'hA5);
    modelWrite(12'h004, 8'h3C);
    modelWrite(12'h008, 8'hFF);
    modelWrite(12'h00C, 8'h00);
    verifyAll("R3");

    // self-targeted send on channel 5 by processor 1
    for (int k = 0; k < 8; k++) modelWrite(12'(12'h428 + k), 8'(8'hC0 + k));
    modelWrite(12'h020, 8'h20);
    busRead(12'h004, v);
    modelWrite(12'h004, v | 8'h20);
    modelWrite(12'h060, 8'h20);
    checkIrq("R7");
    check("R7", "irq1 after self send", {7'b0, irq[1]}, 8'h01);
    busRead(12'h028, v);
    check("R5", "stat1 after send", v, expPend[1]);
    check("R4", "stat1 bit5", {7'b0, v[5]}, 8'h01);
    modelWrite(12'h020, v);
    busRead(12'h004, v);
    modelWrite(12'h004, v & ~8'h20);
    busRead(12'h004, v);
    check("R3", "done bit readback", {7'b0, v[5]}, 8'h00);
    check("R7", "irq1 after receive", {7'b0, irq[1]}, 8'h00);
    busRead(12'h42F, v);
    check("R2", "message byte7", v, 8'hC7);

    // R4/R5/R6/R7 sweep over every trigger value
    modelWrite(12'h004, 8'h3C);
    for (int t = 0; t < 256; t++) begin
      modelWrite(12'h060, 8'(t));
      checkIrq("R7");
      for (int c = 0; c < 4; c++) begin
        busRead(12'(12'h018 + c * 16), v);
        check("R4", $sformatf("stat%0d trig %02h", c, t), v, expPend[c]);
      end
      if (t % 4 == 0) begin
        modelWrite(12'(12'h010 + (t / 4 % 4) * 16), 8'h00);
        busRead(12'(12'h018 + (t / 4 % 4) * 16), v);
        check("R6", "zero clear", v, expPend[t / 4 % 4]);
      end
      modelWrite(12'(12'h010 + (t % 4) * 16), 8'((t * 7) ^ 8'h5A));
      busRead(12'(12'h018 + (t % 4) * 16), v);
      check("R6", $sformatf("partial clear %0d", t), v, expPend[t % 4]);
      checkIrq("R7");
    end
    for (int c = 0; c < 4; c++) modelWrite(12'(12'h010 + c * 16), 8'hFF);
    checkIrq("R7");
    check("R7", "all low", {4'b0, irq}, 8'h00);

    // R8: unmapped accesses
    modelWrite(12'h060, 8'hFF);
    begin
      logic [11:0] holes [12];
      holes = '{12'h001, 12'h002, 12'h003, 12'h005, 12'h011, 12'h014,
                12'h018, 12'h061, 12'h070, 12'h3FF, 12'h440, 12'hFFF};
      for (int h = 0; h < 12; h++) busWrite(holes[h], 8'hFF);
      verifyAll("R8");
      for (int h = 0; h < 12; h++) begin
        if (holes[h] != 12'h018) begin
          busRead(holes[h], v);
          check("R8", $sformatf("read %03h", holes[h]), v, 8'h00);
        end
      end
      busRead(12'h010, v); check("R8", "clear reads 0", v, 8'h00);
      busRead(12'h060, v); check("R8", "trigger reads 0", v, 8'h00);
    end

    // R9: read data returns to 0 when no read is in flight
    busRead(12'h008, v);
    check("R9", "mask2 read", v, 8'hFF);
    @(negedge clk);
    check("R9", "idle rdata", busRdata, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule